// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block is a small bank of 8-bit control registers that sits on a narrow processor bus inside a glue-logic device. Three address bits pick a register. On most registers a fourth address bit turns a write into either a bit-set or a bit-clear operation, so software can change single bits without a read-modify-write. Read data is not an echo of the written value: reads return fixed identification values, live pin levels, or nothing.

The register outputs drive peripheral reset lines, serial-port and PWM routing, wake-source enables, a 7-bit PWM match value, a direction and a drive level for general-purpose pins, and an optional 8-bit TTL output port on spare address pins. While the TTL port is enabled, the low address pins can also be read back as an input port. The PWM counter and the pad drivers sit outside this block.

Top module: `setclr_regbank`

## Requirements
- R1: While reset is low, every writable register is zero: all outputs driven from registers read 0, no pin is an output and the TTL port is disabled.
- R2: On a write with `bus_addr[1]`=0 to a set/clear register (select 000, 001, 010, 100, 101 or 110), each 1 in `bus_wdata` sets the matching bit from the next clock edge on, and every other bit keeps its value.
- R3: On a write with `bus_addr[1]`=1 to a set/clear register, each 1 in `bus_wdata` clears the matching bit, and every other bit keeps its value.
- R4: A write with select 011 loads `bus_wdata[6:0]` into `pwm_match` directly, whatever the value of `bus_addr[1]`.
- R5: Bits 5..2 of the control register (select 000) drive `periph_rst[3:0]` (codec, Ethernet PHY, WLAN, Bluetooth). A read with select 000 returns the parameter `VERSION`.
- R6: A read with select 001 returns `PCB_REV` in bits 7..4, zero in bits 3..1 and the `REDUCED_SPACE` flag in bit 0. Feature bits 6..4 drive `pwm_route[2:0]` and bit 7 drives `pcm_route`.
- R7: The direction register (select 100) drives `pin_oe`, where 1 marks an output. A read with select 100 returns `pin_in`. The level register (select 101) drives `pin_level`.
- R8: Reads with select 010, 011, 101 or 111 return zero.
- R9: With feature bit 3 set, `ttl_oe` is 1, `ttl_out` carries the register written with select 110, and a read with select 110 returns `addr_pin_in`. With feature bit 3 clear, `ttl_oe` is 0, `ttl_out` is 0 and that read returns zero.
- R10: Feature bit 2 (`cf_mode`) forces both serial routes off. Otherwise feature bit 0 drives `uart_to_conn` and bit 1 drives `uart_to_bt`.
- R11: No register changes without `bus_wr`. A write with select 111 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Address bits 4..1: [3:1] register select, [0] clear-not-set |
| bus_wdata | input | 8 | Write data / bit mask |
| bus_rdata | output | 8 | Combinational read data for the current address |
| pin_in | input | 8 | Sampled levels of the general-purpose pins |
| addr_pin_in | input | 8 | Levels on the low address pins |
| periph_rst | output | 4 | Peripheral resets: [0] codec, [1] PHY, [2] WLAN, [3] Bluetooth |
| uart_to_conn | output | 1 | Route serial port to the external connector |
| uart_to_bt | output | 1 | Route serial port to the Bluetooth radio |
| cf_mode | output | 1 | CompactFlash mode |
| pwm_route | output | 3 | PWM output enables for three pins |
| pcm_route | output | 1 | Route Bluetooth audio to the connector |
| hib_ctrl | output | 8 | Hibernate entry and wake-source enables |
| pwm_match | output | 7 | PWM match value |
| pin_oe | output | 8 | Pin direction, 1 = output |
| pin_level | output | 8 | Pin drive levels |
| ttl_oe | output | 1 | TTL output port enabled |
| ttl_out | output | 8 | TTL port value for the high address pins |

## Verification
On every cycle the assertions check the set and clear masks on the hibernate register, the direct PWM load, the hold of all registers between writes, the zero state after reset and the exclusion of serial routing in CompactFlash mode. Only the directed scenarios can show the read values: version, feature word, live pin and address-pin levels, the zero reads, and the TTL gating. They also cover the side effects on the other registers, such as the fact that a write with select 111 touches nothing.

// File: rtl/setclr_regbank.sv
module setclr_regbank #(
  parameter logic [7:0] VERSION       = 8'h07,
  parameter logic [3:0] PCB_REV       = 4'h3,
  parameter logic       REDUCED_SPACE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [4:1] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  input  logic [7:0] addr_pin_in,
  output logic [3:0] periph_rst,
  output logic       uart_to_conn,
  output logic       uart_to_bt,
  output logic       cf_mode,
  output logic [2:0] pwm_route,
  output logic       pcm_route,
  output logic [7:0] hib_ctrl,
  output logic [6:0] pwm_match,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_level,
  output logic       ttl_oe,
  output logic [7:0] ttl_out
);
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_FEAT = 3'd1, SEL_HIB = 3'd2, SEL_PWM = 3'd3,
                         SEL_DIR  = 3'd4, SEL_LVL  = 3'd5, SEL_TTL = 3'd6;

  logic [2:0] sel;
  logic       clr;
  logic [7:0] ctrl_q, feat_q, hib_q, dir_q, lvl_q, ttl_q;
  logic [6:0] pwm_q;

  assign sel = bus_addr[4:2];
  assign clr = bus_addr[1];

  function automatic logic [7:0] apply(input logic [7:0] cur, input logic [7:0] mask, input logic c);
    return c ? (cur & ~mask) : (cur | mask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; feat_q <= '0; hib_q <= '0; pwm_q <= '0;
      dir_q  <= '0; lvl_q  <= '0; ttl_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_CTRL: ctrl_q <= apply(ctrl_q, bus_wdata, clr);
        SEL_FEAT: feat_q <= apply(feat_q, bus_wdata, clr);
        SEL_HIB:  hib_q  <= apply(hib_q, bus_wdata, clr);
        SEL_PWM:  pwm_q  <= bus_wdata[6:0];
        SEL_DIR:  dir_q  <= apply(dir_q, bus_wdata, clr);
        SEL_LVL:  lvl_q  <= apply(lvl_q, bus_wdata, clr);
        SEL_TTL:  ttl_q  <= apply(ttl_q, bus_wdata, clr);
        default: ;
      endcase
    end
  end

  assign periph_rst   = ctrl_q[5:2];
  assign cf_mode      = feat_q[2];
  assign uart_to_conn = feat_q[0] & ~feat_q[2];
  assign uart_to_bt   = feat_q[1] & ~feat_q[2];
  assign ttl_oe       = feat_q[3];
  assign pwm_route    = feat_q[6:4];
  assign pcm_route    = feat_q[7];
  assign hib_ctrl     = hib_q;
  assign pwm_match    = pwm_q;
  assign pin_oe       = dir_q;
  assign pin_level    = lvl_q;
  assign ttl_out      = feat_q[3] ? ttl_q : 8'h00;

  always_comb begin
    case (sel)
      SEL_CTRL: bus_rdata = VERSION;
      SEL_FEAT: bus_rdata = {PCB_REV, 3'b000, REDUCED_SPACE};
      SEL_DIR:  bus_rdata = pin_in;
      SEL_TTL:  bus_rdata = feat_q[3] ? addr_pin_in : 8'h00;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == 0 && feat_q == 0 && hib_q == 0 && pwm_q == 0 &&
                dir_q == 0 && lvl_q == 0 && ttl_q == 0));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel == SEL_HIB && !clr |=>
      ((hib_q & $past(bus_wdata)) == $past(bus_wdata)) && (($past(hib_q) & ~hib_q) == 0));

  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel == SEL_HIB && clr |=>
      ((hib_q & $past(bus_wdata)) == 0) && ((hib_q & ~$past(hib_q)) == 0));

  assert_pwm_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel == SEL_PWM |=> pwm_match == $past(bus_wdata[6:0]));

  assert_uart_off_in_cf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cf_mode |-> !uart_to_conn && !uart_to_bt);

  assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({ctrl_q, feat_q, hib_q, pwm_q, dir_q, lvl_q, ttl_q}));
endmodule

// File: tb/setclr_regbank_bench.sv
module setclr_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:1] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] addr_pin_in = '0;
  logic [3:0] periph_rst;
  logic       uart_to_conn, uart_to_bt, cf_mode, pcm_route, ttl_oe;
  logic [2:0] pwm_route;
  logic [7:0] hib_ctrl, pin_oe, pin_level, ttl_out;
  logic [6:0] pwm_match;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  setclr_regbank u_setclr_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .addr_pin_in(addr_pin_in), .periph_rst(periph_rst), .uart_to_conn(uart_to_conn),
    .uart_to_bt(uart_to_bt), .cf_mode(cf_mode), .pwm_route(pwm_route),
    .pcm_route(pcm_route), .hib_ctrl(hib_ctrl), .pwm_match(pwm_match),
    .pin_oe(pin_oe), .pin_level(pin_level), .ttl_oe(ttl_oe), .ttl_out(ttl_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic c, input logic [7:0] d);
    @(negedge clk);
    bus_addr = {sel, c}; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    bus_addr = {sel, 1'b0};
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 pin_oe", pin_oe, 0);
    check("R1 hib", hib_ctrl, 0);
    check("R1 pwm", pwm_match, 0);
    check("R1 ttl_oe", ttl_oe, 0);
    check("R1 periph_rst", periph_rst, 0);
    rd(3'd6, r); check("R1 ttl read off", r, 0);
  endtask

  task automatic t_set_clear();
    wr(3'd2, 1'b0, 8'h0F); check("R2 set", hib_ctrl, 8'h0F);
    wr(3'd2, 1'b0, 8'h30); check("R2 set keeps others", hib_ctrl, 8'h3F);
    wr(3'd2, 1'b1, 8'h05); check("R3 clear", hib_ctrl, 8'h3A);
    wr(3'd2, 1'b1, 8'h00); check("R3 clear zero mask", hib_ctrl, 8'h3A);
    wr(3'd5, 1'b0, 8'hA5); check("R2 level set", pin_level, 8'hA5);
    wr(3'd5, 1'b1, 8'h81); check("R3 level clear", pin_level, 8'h24);
  endtask

  task automatic t_pwm();
    logic [7:0] r;
    wr(3'd3, 1'b1, 8'hD5); check("R4 pwm load clr bit", pwm_match, 7'h55);
    wr(3'd3, 1'b0, 8'h12); check("R4 pwm overwrite", pwm_match, 7'h12);
    rd(3'd3, r); check("R8 pwm read zero", r, 0);
  endtask

  task automatic t_ctrl_feat();
    logic [7:0] r;
    wr(3'd0, 1'b0, 8'h14); check("R5 resets", periph_rst, 4'b0101);
    wr(3'd0, 1'b1, 8'h04); check("R5 reset clear", periph_rst, 4'b0100);
    rd(3'd0, r); check("R5 version", r, 8'h07);
    rd(3'd1, r); check("R6 feature read", r, 8'h31);
    wr(3'd1, 1'b0, 8'hD0); check("R6 pwm_route", pwm_route, 3'b101);
    check("R6 pcm_route", pcm_route, 1);
    wr(3'd1, 1'b1, 8'hF0);
  endtask

  task automatic t_pins();
    logic [7:0] r;
    wr(3'd4, 1'b0, 8'h1B); check("R7 pin_oe", pin_oe, 8'h1B);
    pin_in = 8'h6C;
    rd(3'd4, r); check("R7 pin read", r, 8'h6C);
    rd(3'd5, r); check("R8 level read zero", r, 0);
    rd(3'd2, r); check("R8 hib read zero", r, 0);
  endtask

  task automatic t_ttl();
    logic [7:0] r;
    wr(3'd6, 1'b0, 8'hC3);
    check("R9 ttl off oe", ttl_oe, 0);
    check("R9 ttl off out", ttl_out, 0);
    addr_pin_in = 8'h9E;
    rd(3'd6, r); check("R9 ttl off read", r, 0);
    wr(3'd1, 1'b0, 8'h08);
    check("R9 ttl on oe", ttl_oe, 1);
    check("R9 ttl on out", ttl_out, 8'hC3);
    rd(3'd6, r); check("R9 ttl on read", r, 8'h9E);
  endtask

  task automatic t_uart();
    wr(3'd1, 1'b0, 8'h03);
    check("R10 conn", uart_to_conn, 1);
    check("R10 bt", uart_to_bt, 1);
    wr(3'd1, 1'b0, 8'h04);
    check("R10 cf gates conn", uart_to_conn, 0);
    check("R10 cf gates bt", uart_to_bt, 0);
    wr(3'd1, 1'b1, 8'h05);
    check("R10 bt only", {uart_to_conn, uart_to_bt}, 2'b01);
  endtask

  task automatic t_no_write();
    logic [7:0] r;
    @(negedge clk);
    bus_addr = {3'd2, 1'b0}; bus_wdata = 8'hFF;
    @(negedge clk);
    check("R11 no strobe", hib_ctrl, 8'h3A);
    wr(3'd7, 1'b0, 8'hFF);
    check("R11 sel7 hib", hib_ctrl, 8'h3A);
    check("R11 sel7 oe", pin_oe, 8'h1B);
    check("R11 sel7 pwm", pwm_match, 7'h12);
    rd(3'd7, r); check("R8 sel7 read zero", r, 0);
  endtask

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_set_clear();
    t_pwm();
    t_ctrl_feat();
    t_pins();
    t_ttl();
    t_uart();
    t_no_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule